// File: doc/BRIEF.md
# Partitioned LRU Line Buffer Allocator

This block tracks four line buffers placed in front of a slow flash array. Each read arrives as a line address plus a flag that marks it as an instruction fetch or a data read. The block compares the line against all four buffer tags. On a hit it reports the buffer. On a miss it picks the least-recently-used buffer among those the access type may use, claims that buffer for the line and asks the flash for a fill. The flash answers each fill request with a one-cycle acknowledge. The line data and the flash timing stay outside the block.

A two-bit partition code chooses which buffers each access type may use. Instruction fetches and data reads each have their own prefetch enable. When prefetch applies, the block fetches the next sequential line into the oldest buffer of the same group. That buffer does not become most-recently-used until an access hits it. A global buffer enable turns the buffers off, and every access then goes straight to the flash.

The controller has four states. ST_IDLE accepts an access. ST_DEMAND_FILL holds a demand fill request until it is acknowledged. ST_PF_PICK checks for a prefetch and claims its victim. ST_PF_FILL holds the prefetch fill request until it is acknowledged. The transitions are:
- ST_IDLE goes to ST_DEMAND_FILL on a miss or when buffers are disabled.
- ST_IDLE goes to ST_PF_PICK on a hit when prefetch applies.
- ST_DEMAND_FILL goes to ST_PF_PICK, or back to ST_IDLE, on the acknowledge.
- ST_PF_PICK goes to ST_PF_FILL when the next line is absent, or to ST_IDLE when it is already present.
- ST_PF_FILL goes to ST_IDLE on the acknowledge.

Top module: `lbuf_alloc_ctrl`

## Requirements
- R1: An access is accepted only in ST_IDLE. One cycle after acceptance, `resp_valid` pulses. `resp_hit` is 1 when a valid buffer tag equals the line, and `resp_idx` gives that buffer; when several tags match, the lowest index is reported.
- R2: Partition code 2'b00 lets every access type use all four buffers. The reserved code 2'b01 behaves the same way.
- R3: Partition code 2'b10 restricts instruction fetches to buffers 0 and 1 and data reads to buffers 2 and 3.
- R4: Partition code 2'b11 restricts instruction fetches to buffers 0, 1 and 2 and data reads to buffer 3.
- R5: On a miss, the oldest buffer in the allowed group is claimed for the line, reported on `resp_idx` and made most-recently-used. A fill request follows with `fill_is_pf`=0, `fill_line` set to the line and `fill_idx` set to that buffer. `fill_req` stays high until `fill_ack`.
- R6: A hit makes the hit buffer most-recently-used, and it becomes the last choice for later victims.
- R7: A prefetch fetches line+1, wrapping modulo the line space, into the oldest buffer of the group. The fill request carries `fill_is_pf`=1 and comes after any demand fill. The prefetched buffer keeps its age until an access hits it.
- R8: A prefetch is considered only when `buf_en`=1 and the enable for the access type is set: `ipf_en` for instruction fetches, `dpf_en` for data reads.
- R9: A prefetch is dropped when line+1 is already valid in a buffer of the same group, or when the group has only one buffer.
- R10: When `buf_en`=0, every access reports a miss with `resp_idx`=0 and raises a demand fill with `fill_idx`=0. Tags and ages are left unchanged and no prefetch follows.
- R11: While `busy`=1, `acc_valid` is ignored and produces no response.
- R12: Reset leaves all buffers invalid, `busy`, `resp_valid` and `fill_req` low, and the age order with buffer 3 oldest and buffer 0 youngest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request |
| acc_line | input | LINE_W | Line address of the access |
| acc_is_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| part_cfg | input | 2 | Partition code |
| buf_en | input | 1 | Buffer enable |
| ipf_en | input | 1 | Prefetch enable for instruction fetches |
| dpf_en | input | 1 | Prefetch enable for data reads |
| fill_ack | input | 1 | Flash has completed the current fill |
| busy | output | 1 | Controller is not in ST_IDLE |
| resp_valid | output | 1 | Lookup result valid (one-cycle pulse) |
| resp_hit | output | 1 | Lookup hit |
| resp_idx | output | 2 | Buffer hit or claimed |
| fill_req | output | 1 | Fill request to the flash |
| fill_line | output | LINE_W | Line to fetch |
| fill_idx | output | 2 | Buffer receiving the fill |
| fill_is_pf | output | 1 | Fill is a prefetch |

## Verification
The lookup and allocation path is exercised with repeated misses in shared-pool mode, in the reserved code and in both split codes. The same lines are later revisited, so the results separate per-group victim choice from global choice. A hit on a just-prefetched line, followed by further misses, separates promotion on hit from promotion on fill. Re-reading a line whose successor is already buffered, data reads in the one-buffer group, and the top line of the address space check prefetch dropping and wraparound. A run with buffers disabled, followed by revisits with them enabled again, shows that no tag or age changed. A request raised during a fill shows that the block ignores it.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

    localparam int NBUF  = 4;
    localparam int IDX_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DEMAND_FILL,
        ST_PF_PICK,
        ST_PF_FILL
    } ctrl_state_e;

    // Buffers an access type may use under a given partition code.
    function automatic logic [NBUF-1:0] group_mask(input logic [1:0] cfg,
                                                   input logic is_instr);
        case (cfg)
            2'b10:   return is_instr ? 4'b0011 : 4'b1100;
            2'b11:   return is_instr ? 4'b0111 : 4'b1000;
            default: return 4'b1111; // shared pool, reserved code included
        endcase
    endfunction

endpackage

// File: rtl/lbuf_tag_array.sv
module lbuf_tag_array
    import lbuf_pkg::*;
#(
    parameter int LINE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] look_line,
    input  logic [LINE_W-1:0] probe_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    output logic [NBUF-1:0]   look_hit,
    output logic [NBUF-1:0]   probe_hit
);

    for (genvar g = 0; g < NBUF; g++) begin : g_entry
        logic [LINE_W-1:0] tag_q;
        logic              vld_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q <= '0;
                vld_q <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                tag_q <= wr_line;
                vld_q <= 1'b1;
            end
        end

        assign look_hit[g]  = vld_q && (tag_q == look_line);
        assign probe_hit[g] = vld_q && (tag_q == probe_line);
    end

endmodule

// File: rtl/lbuf_lru_rank.sv
module lbuf_lru_rank
    import lbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [NBUF-1:0]  sel_mask,
    output logic [IDX_W-1:0] victim_idx
);

    // Age 0 = most recently used, NBUF-1 = oldest.
    logic [IDX_W-1:0] age_q [NBUF];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBUF; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < NBUF; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // Oldest buffer among those the mask permits.
    always_comb begin
        logic             found;
        logic [IDX_W-1:0] best_age;
        found      = 1'b0;
        best_age   = '0;
        victim_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (sel_mask[i] && (!found || age_q[i] > best_age)) begin
                found      = 1'b1;
                best_age   = age_q[i];
                victim_idx = IDX_W'(i);
            end
        end
    end

    // Ages must stay a permutation: each rank held by exactly one buffer.
    for (genvar r = 0; r < NBUF; r++) begin : g_rank_chk
        logic [NBUF-1:0] holders;
        for (genvar b = 0; b < NBUF; b++) begin : g_b
            assign holders[b] = (age_q[b] == IDX_W'(r));
        end
        a_r6_rank_unique: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(holders) == 1);
    end

endmodule

// File: rtl/lbuf_alloc_ctrl.sv
module lbuf_alloc_ctrl
    import lbuf_pkg::*;
#(
    parameter int LINE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [LINE_W-1:0] acc_line,
    input  logic              acc_is_instr,
    input  logic [1:0]        part_cfg,
    input  logic              buf_en,
    input  logic              ipf_en,
    input  logic              dpf_en,
    input  logic              fill_ack,
    output logic              busy,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [1:0]        resp_idx,
    output logic              fill_req,
    output logic [LINE_W-1:0] fill_line,
    output logic [1:0]        fill_idx,
    output logic              fill_is_pf
);

    localparam int MIN_PF_GROUP = 2;

    ctrl_state_e state_q, state_d;

    logic [NBUF-1:0]   mask_q;
    logic              pf_pend_q;
    logic [LINE_W-1:0] pf_line_q;

    logic              accept;
    logic [NBUF-1:0]   acc_mask, lru_mask;
    logic [NBUF-1:0]   look_hit, probe_hit;
    logic              hit_any, pf_held, pf_want;
    logic [IDX_W-1:0]  hit_idx, victim;
    logic              tag_wr, lru_touch;

    assign accept   = acc_valid && (state_q == ST_IDLE);
    assign acc_mask = group_mask(part_cfg, acc_is_instr);
    assign hit_any  = |look_hit;
    assign lru_mask = (state_q == ST_PF_PICK) ? mask_q : acc_mask;
    assign pf_held  = |(probe_hit & mask_q);
    assign pf_want  = buf_en && (acc_is_instr ? ipf_en : dpf_en)
                      && ($countones(acc_mask) >= MIN_PF_GROUP);

    always_comb begin
        hit_idx = '0;
        for (int i = NBUF - 1; i >= 0; i--)
            if (look_hit[i]) hit_idx = IDX_W'(i);
    end

    assign tag_wr    = (accept && buf_en && !hit_any)
                       || (state_q == ST_PF_PICK && !pf_held);
    assign lru_touch = accept && buf_en;

    lbuf_tag_array #(.LINE_W(LINE_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_line  (acc_line),
        .probe_line (pf_line_q),
        .wr_en      (tag_wr),
        .wr_idx     (victim),
        .wr_line    (accept ? acc_line : pf_line_q),
        .look_hit   (look_hit),
        .probe_hit  (probe_hit)
    );

    lbuf_lru_rank u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (lru_touch),
        .touch_idx  (hit_any ? hit_idx : victim),
        .sel_mask   (lru_mask),
        .victim_idx (victim)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!buf_en || !hit_any) state_d = ST_DEMAND_FILL;
                    else if (pf_want)        state_d = ST_PF_PICK;
                end
            end
            ST_DEMAND_FILL: begin
                if (fill_ack) state_d = pf_pend_q ? ST_PF_PICK : ST_IDLE;
            end
            ST_PF_PICK: begin
                state_d = pf_held ? ST_IDLE : ST_PF_FILL;
            end
            ST_PF_FILL: begin
                if (fill_ack) state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs and access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_idx   <= '0;
            fill_line  <= '0;
            fill_idx   <= '0;
            fill_is_pf <= 1'b0;
            mask_q     <= '0;
            pf_pend_q  <= 1'b0;
            pf_line_q  <= '0;
        end else begin
            resp_valid <= accept;
            if (accept) begin
                resp_hit   <= buf_en && hit_any;
                resp_idx   <= !buf_en ? '0 : (hit_any ? hit_idx : victim);
                fill_line  <= acc_line;
                fill_idx   <= buf_en ? victim : '0;
                fill_is_pf <= 1'b0;
                mask_q     <= acc_mask;
                pf_pend_q  <= pf_want;
                pf_line_q  <= acc_line + 1'b1;
            end else if (state_q == ST_PF_PICK && !pf_held) begin
                fill_line  <= pf_line_q;
                fill_idx   <= victim;
                fill_is_pf <= 1'b1;
            end
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign fill_req = (state_q == ST_DEMAND_FILL) || (state_q == ST_PF_FILL);

    a_r11_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && busy) |=> !resp_valid);

    a_r1_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($past(acc_valid) && $past(state_q) == ST_IDLE));

    a_r7_pf_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_is_pf) |-> mask_q[fill_idx]);

    a_r9_pf_group_size: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_is_pf) |-> ($countones(mask_q) > 1));

    a_r5_fill_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_ack) |=> (fill_req && $stable(fill_line) && $stable(fill_idx)));

endmodule

// File: tb/sim_lbuf_alloc_ctrl.sv
module sim_lbuf_alloc_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [LW-1:0] acc_line = '0;
    logic          acc_is_instr = 1'b0;
    logic [1:0]    part_cfg = 2'b00;
    logic          buf_en = 1'b1;
    logic          ipf_en = 1'b0;
    logic          dpf_en = 1'b1;
    logic          fill_ack = 1'b0;
    logic          busy, resp_valid, resp_hit, fill_req, fill_is_pf;
    logic [1:0]    resp_idx, fill_idx;
    logic [LW-1:0] fill_line;

    int tests = 0;
    int fails = 0;

    // Reference model state
    int          m_age [4];
    logic [LW-1:0] m_tag [4];
    bit          m_val [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    lbuf_alloc_ctrl #(.LINE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
        .acc_is_instr(acc_is_instr), .part_cfg(part_cfg), .buf_en(buf_en),
        .ipf_en(ipf_en), .dpf_en(dpf_en), .fill_ack(fill_ack), .busy(busy),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_idx(resp_idx),
        .fill_req(fill_req), .fill_line(fill_line), .fill_idx(fill_idx),
        .fill_is_pf(fill_is_pf)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [3:0] gmask(input logic [1:0] cfg, input bit instr);
        if (cfg == 2'b10) return instr ? 4'b0011 : 4'b1100;
        if (cfg == 2'b11) return instr ? 4'b0111 : 4'b1000;
        return 4'b1111;
    endfunction

    function automatic int pick_victim(input logic [3:0] mk);
        int best = -1;
        for (int i = 0; i < 4; i++)
            if (mk[i] && (best < 0 || m_age[i] > m_age[best])) best = i;
        return best;
    endfunction

    task automatic promote(input int b);
        int old = m_age[b];
        for (int j = 0; j < 4; j++) if (m_age[j] < old) m_age[j]++;
        m_age[b] = 0;
    endtask

    task automatic expect_fill(input string rq, input logic [LW-1:0] ln,
                               input int idx, input int pf);
        int n = 0;
        while (!fill_req && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(rq, "fill_req", fill_req, 1);
        chk(rq, "fill_line", fill_line, ln);
        chk(rq, "fill_idx", fill_idx, idx);
        chk(rq, "fill_is_pf", fill_is_pf, pf);
        fill_ack = 1'b1;
        @(negedge clk);
        fill_ack = 1'b0;
    endtask

    task automatic wait_idle(input string rq);
        int n = 0;
        while (busy && n < 20) begin
            if (fill_req) chk(rq, "unexpected fill", 1, 0);
            @(negedge clk);
            n++;
        end
        chk(rq, "idle busy", busy, 0);
        chk(rq, "idle fill_req", fill_req, 0);
    endtask

    task automatic do_access(input logic [LW-1:0] ln, input bit instr,
                             input bit poke, input string rq);
        logic [3:0]    mk;
        logic [LW-1:0] nxt;
        bit hit, dfill, pfill, held;
        int hidx, eidx, didx, pidx;
        mk = gmask(part_cfg, instr);
        hit = 0; hidx = 0; dfill = 0; pfill = 0; didx = 0; pidx = 0;
        if (buf_en) begin
            for (int i = 0; i < 4; i++)
                if (!hit && m_val[i] && m_tag[i] == ln) begin
                    hit = 1; hidx = i;
                end
        end
        if (!buf_en) begin
            eidx = 0; dfill = 1; didx = 0;
        end else if (hit) begin
            eidx = hidx; promote(hidx);
        end else begin
            eidx = pick_victim(mk);
            m_tag[eidx] = ln; m_val[eidx] = 1; promote(eidx);
            dfill = 1; didx = eidx;
        end
        if (buf_en && (instr ? ipf_en : dpf_en) && $countones(mk) > 1) begin
            nxt = ln + 1'b1;
            held = 0;
            for (int i = 0; i < 4; i++)
                if (mk[i] && m_val[i] && m_tag[i] == nxt) held = 1;
            if (!held) begin
                pidx = pick_victim(mk);
                m_tag[pidx] = nxt; m_val[pidx] = 1;
                pfill = 1;
            end
        end
        acc_valid = 1'b1; acc_line = ln; acc_is_instr = instr;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(rq, "resp_valid", resp_valid, 1);
        chk(rq, "resp_hit", resp_hit, hit);
        chk(rq, "resp_idx", resp_idx, eidx);
        if (dfill) begin
            if (poke) begin
                // R11: request raised during a fill must be ignored
                acc_valid = 1'b1; acc_line = ln + 20'd7;
                @(negedge clk);
                acc_valid = 1'b0;
                chk("R11", "resp_valid while busy", resp_valid, 0);
                chk("R11", "still busy", busy, 1);
            end
            expect_fill(rq, ln, didx, 0);
        end
        if (pfill) expect_fill(rq, nxt, pidx, 1);
        wait_idle(rq);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_age[i] = i; m_tag[i] = '0; m_val[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "busy", busy, 0);
        chk("R12", "resp_valid", resp_valid, 0);
        chk("R12", "fill_req", fill_req, 0);

        // Shared pool, data prefetch on, instruction prefetch off
        do_access(20'h00010, 0, 0, "R5");
        do_access(20'h00011, 0, 0, "R7");
        do_access(20'h00020, 1, 0, "R8");
        do_access(20'h00010, 0, 0, "R6");
        do_access(20'h00030, 0, 0, "R2");
        do_access(20'h00020, 1, 0, "R1");

        part_cfg = 2'b01;
        do_access(20'h00040, 1, 0, "R2");
        do_access(20'h00050, 0, 0, "R2");

        part_cfg = 2'b10; ipf_en = 1'b1;
        do_access(20'h00100, 1, 0, "R3");
        do_access(20'h00101, 1, 0, "R7");
        do_access(20'h00200, 0, 0, "R3");
        do_access(20'h00200, 0, 0, "R9");
        do_access(20'h00300, 1, 0, "R3");
        do_access(20'h00050, 1, 0, "R3");

        part_cfg = 2'b11;
        do_access(20'h00400, 0, 0, "R4");
        do_access(20'h00500, 1, 0, "R4");
        do_access(20'h00501, 1, 0, "R4");
        do_access(20'h00600, 0, 0, "R9");
        do_access(20'h00700, 1, 1, "R4");

        part_cfg = 2'b00;
        do_access(20'hFFFFF, 1, 0, "R7");
        do_access(20'h00000, 1, 0, "R7");

        buf_en = 1'b0;
        do_access(20'h00000, 1, 0, "R10");
        do_access(20'h00900, 0, 0, "R10");
        buf_en = 1'b1;
        do_access(20'hFFFFF, 1, 0, "R10");
        do_access(20'h00001, 0, 0, "R10");

        dpf_en = 1'b0; ipf_en = 1'b0;
        do_access(20'h00A00, 0, 0, "R8");
        do_access(20'h00B00, 1, 0, "R8");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule